// File: doc/BRIEF.md
# Chip-Enable Write-Protect Gate

This block sits between a memory controller's active-low chip-enable and a battery-backed RAM. It protects the RAM while a supply supervisor holds the system in reset. In normal operation the chip-enable passes through with no register in its path. When the supervisor asserts its active-low reset, the gate closes and holds the RAM's chip-enable at the inactive-high level, so that writes made during a brownout cannot corrupt the stored data.

A write that is already under way when reset arrives is allowed to finish. If chip-enable is low at the first clock edge that sees reset, the gate stays open until chip-enable returns high or until a grace window of `GRACE_TICKS` clock edges runs out, whichever comes first. At 125 MHz the default of 1250 ticks is 10 µs.

After reset is released, the gate reopens only at a clock edge where chip-enable is high, so the RAM never receives the tail of a low pulse. A status output reports whether the gate is open.

Top module: `ce_write_guard`

## Requirements
- R1: While the gate is open (`gate_open`=1), `ce_out_n` equals `ce_in_n` in the same cycle, with no clock delay.
- R2: While the gate is closed (`gate_open`=0), `ce_out_n` is 1 whatever `ce_in_n` does.
- R3: If the gate is open and a clock edge samples `sup_rst_n`=0 with `ce_in_n`=1, the gate is closed after that edge.
- R4: If the gate is open and a clock edge samples `sup_rst_n`=0 with `ce_in_n`=0, the gate stays open. It closes at the first later edge that samples `ce_in_n`=1 while `sup_rst_n` is still 0.
- R5: If `ce_in_n` stays 0 and `sup_rst_n` stays 0, the gate closes at the `GRACE_TICKS`-th edge after the edge that first saw reset. It is open for exactly `GRACE_TICKS` cycles after that first edge.
- R6: Once closed, the gate stays closed for as long as `sup_rst_n` is 0.
- R7: A closed gate reopens only after an edge that samples `sup_rst_n`=1 and `ce_in_n`=1. While `ce_in_n` stays 0 it stays closed.
- R8: The synchronous active-high `rst` puts the gate in the closed state (`gate_open`=0, `ce_out_n`=1).
- R9: If `sup_rst_n` returns to 1 during the grace window, the gate stays open and returns to normal pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the enable decision |
| rst | input | 1 | Synchronous active-high initialisation |
| sup_rst_n | input | 1 | Supervisor reset, active low |
| ce_in_n | input | 1 | Chip-enable from the memory controller, active low |
| ce_out_n | output | 1 | Gated chip-enable to the RAM, active low |
| gate_open | output | 1 | 1 while the gate passes chip-enable |

## Verification
Reset is asserted in three situations: while chip-enable is idle, in the middle of a short write that ends inside the grace window, and during a write held low past the window. These separate an immediate close, an early close when the write ends, and a close forced by the timeout at an exact cycle. A fourth run releases reset while still inside the window, which shows that the gate resumes normal pass-through rather than closing. Chip-enable is also held low across the release of reset, which shows that re-opening waits for an idle chip-enable. Toggling chip-enable inside a single cycle while the gate is open confirms that the path has no clock delay.

// File: rtl/ceg_pkg.sv
`timescale 1ns/1ps
package ceg_pkg;

    typedef enum logic [1:0] {
        GS_OPEN  = 2'd0,
        GS_GRACE = 2'd1,
        GS_SHUT  = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic start;
        logic run;
    } timer_ctl_t;

    function automatic int unsigned tick_width(input int unsigned ticks);
        return (ticks <= 2) ? 1 : $clog2(ticks);
    endfunction

endpackage

// File: rtl/ceg_grace_timer.sv
`timescale 1ns/1ps
module ceg_grace_timer
    import ceg_pkg::*;
#(
    parameter int unsigned GRACE_TICKS = 1250
) (
    input  logic       clk,
    input  logic       rst,
    input  timer_ctl_t ctl,
    output logic       expired
);
    localparam int unsigned CW = tick_width(GRACE_TICKS);
    localparam logic [CW-1:0] LAST = CW'(GRACE_TICKS - 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || ctl.start) begin
            cnt <= '0;
        end else if (ctl.run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/ceg_gate_ctrl.sv
`timescale 1ns/1ps
module ceg_gate_ctrl
    import ceg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sup_rst_n,
    input  logic        ce_in_n,
    input  logic        expired,
    output timer_ctl_t  tctl,
    output logic        open_q
);
    gate_state_e state, state_nx;

    always_comb begin
        state_nx   = state;
        tctl.start = 1'b0;
        tctl.run   = 1'b0;
        unique case (state)
            GS_OPEN: begin
                if (!sup_rst_n) begin
                    if (ce_in_n) begin
                        state_nx = GS_SHUT;
                    end else begin
                        state_nx   = GS_GRACE;
                        tctl.start = 1'b1;
                    end
                end
            end
            GS_GRACE: begin
                tctl.run = 1'b1;
                if (sup_rst_n) begin
                    state_nx = GS_OPEN;
                end else if (ce_in_n || expired) begin
                    state_nx = GS_SHUT;
                end
            end
            GS_SHUT: begin
                if (sup_rst_n && ce_in_n) begin
                    state_nx = GS_OPEN;
                end
            end
            default: state_nx = GS_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GS_SHUT;
        end else begin
            state <= state_nx;
        end
    end

    assign open_q = (state != GS_SHUT);

    assert_idle_close_R3: assert property (@(posedge clk) disable iff (rst)
        (state == GS_OPEN && !sup_rst_n && ce_in_n) |=> (state == GS_SHUT));

    assert_write_done_close_R4: assert property (@(posedge clk) disable iff (rst)
        (state == GS_GRACE && !sup_rst_n && ce_in_n) |=> (state == GS_SHUT));

    assert_timeout_close_R5: assert property (@(posedge clk) disable iff (rst)
        (state == GS_GRACE && !sup_rst_n && expired) |=> (state == GS_SHUT));

    assert_hold_shut_R6: assert property (@(posedge clk) disable iff (rst)
        (state == GS_SHUT && !sup_rst_n) |=> (state == GS_SHUT));

    assert_no_partial_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (state == GS_SHUT && !ce_in_n) |=> (state == GS_SHUT));

endmodule

// File: rtl/ceg_pass.sv
`timescale 1ns/1ps
module ceg_pass (
    input  logic open_q,
    input  logic ce_in_n,
    output logic ce_out_n
);
    always_comb begin
        ce_out_n = open_q ? ce_in_n : 1'b1;
    end
endmodule

// File: rtl/ce_write_guard.sv
`timescale 1ns/1ps
module ce_write_guard
    import ceg_pkg::*;
#(
    parameter int unsigned GRACE_TICKS = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_rst_n,
    input  logic ce_in_n,
    output logic ce_out_n,
    output logic gate_open
);
    timer_ctl_t tctl;
    logic       expired;
    logic       open_q;

    ceg_grace_timer #(.GRACE_TICKS(GRACE_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ctl     (tctl),
        .expired (expired)
    );

    ceg_gate_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sup_rst_n (sup_rst_n),
        .ce_in_n   (ce_in_n),
        .expired   (expired),
        .tctl      (tctl),
        .open_q    (open_q)
    );

    ceg_pass u_pass (
        .open_q   (open_q),
        .ce_in_n  (ce_in_n),
        .ce_out_n (ce_out_n)
    );

    assign gate_open = open_q;

    assert_closed_inactive_R2: assert property (@(posedge clk) disable iff (rst)
        !gate_open |-> ce_out_n);

    assert_init_closed_R8: assert property (@(posedge clk)
        rst |=> !gate_open);

endmodule

// File: tb/ce_write_guard_bench.sv
`timescale 1ns/1ps
module ce_write_guard_bench;
    localparam int G = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup_rst_n = 1'b0;
    logic ce_in_n = 1'b1;
    logic ce_out_n, gate_open;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // reference model: 0 = passing, 1 = finishing a write, 2 = blocked
    int m_mode = 2;
    int m_ticks = 0;

    always #4 clk = ~clk;

    ce_write_guard #(.GRACE_TICKS(G)) u_ce_write_guard (
        .clk(clk), .rst(rst), .sup_rst_n(sup_rst_n), .ce_in_n(ce_in_n),
        .ce_out_n(ce_out_n), .gate_open(gate_open)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 2;
        end else if (m_mode == 0) begin
            if (!sup_rst_n) begin
                if (ce_in_n) m_mode = 2;
                else begin m_mode = 1; m_ticks = 0; end
            end
        end else if (m_mode == 1) begin
            m_ticks = m_ticks + 1;
            if (sup_rst_n) m_mode = 0;
            else if (ce_in_n || m_ticks >= G) m_mode = 2;
        end else begin
            if (sup_rst_n && ce_in_n) m_mode = 0;
        end
    end

    task automatic check(input string tag);
        logic exp_open, exp_out;
        exp_open = (m_mode != 2);
        exp_out = exp_open ? ce_in_n : 1'b1;
        n_checks++;
        if (gate_open !== exp_open) begin
            n_fail++;
            $display("FAIL %s gate_open actual=%b expected=%b", tag, gate_open, exp_open);
        end
        n_checks++;
        if (ce_out_n !== exp_out) begin
            n_fail++;
            $display("FAIL %s ce_out_n actual=%b expected=%b", tag, ce_out_n, exp_out);
        end
    endtask

    task automatic step(input logic s, input logic c, input string tag);
        @(negedge clk);
        sup_rst_n = s;
        ce_in_n = c;
        #1;
        check(tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=done", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        step(0, 1, "R8");
        step(0, 0, "R8");
        @(negedge clk); rst = 0;
        // supervisor reset held: stays blocked
        for (int i = 0; i < 3; i++) step(0, i[0], "R6");
        // released but ce low: no reopen
        for (int i = 0; i < 3; i++) step(1, 0, "R7");
        step(1, 1, "R7");
        step(1, 1, "R7");
        // pass-through with intra-cycle toggles
        for (int i = 0; i < 4; i++) begin
            step(1, 0, "R1");
            #1; ce_in_n = 1'b1; #1; check("R1");
            ce_in_n = 1'b0; #1; check("R1");
        end
        // idle ce at reset: immediate close
        step(1, 1, "R1");
        step(0, 1, "R3");
        step(0, 0, "R3");
        step(0, 0, "R2");
        step(1, 1, "R7");
        step(1, 1, "R7");
        // short write finishes inside window
        step(1, 0, "R1");
        step(0, 0, "R4");
        for (int i = 0; i < 3; i++) step(0, 0, "R4");
        step(0, 1, "R4");
        step(0, 0, "R4");
        step(0, 0, "R6");
        step(1, 1, "R7");
        step(1, 1, "R7");
        // write held past window
        step(1, 0, "R1");
        for (int i = 0; i < G + 4; i++) step(0, 0, "R5");
        step(0, 1, "R2");
        step(1, 1, "R7");
        step(1, 1, "R7");
        // release during window
        step(1, 0, "R1");
        step(0, 0, "R9");
        step(0, 0, "R9");
        for (int i = 0; i < G + 2; i++) step(1, 0, "R9");
        step(1, 1, "R9");
        step(1, 0, "R9");
        // reset mid-operation
        @(negedge clk); rst = 1;
        step(1, 0, "R8");
        @(negedge clk); rst = 0;
        step(1, 0, "R8");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule